// File: doc/BRIEF.md
# Four-Register ALU Datapath with Constant Load

This block holds four 8-bit working registers and performs one operation per clock. An 8-bit operand field carries two register selects, one in its low two bits for the first operand and one in the next two bits for the second. Each select drives its own 4-to-1 selector. Those selectors feed a small ALU. A 2-bit destination select steers the result into one register on the next rising edge. A carry flag is captured next to the registers. All register contents are visible on a flat output bus.

One reserved operation code does not compute anything. For that code the whole 8-bit operand field is taken as a constant. The constant bypasses the ALU through a 2-to-1 result selector and is written to the destination register. This lets software seed registers without a separate immediate path. A write-enable input gates every state change.

Top module: `regAluCore`

## Requirements
- R1: A synchronous active-high reset clears all four registers and the carry flag to zero.
- R2: When writeEn is low at a rising edge, no register and not the carry flag changes.
- R3: An update writes only the register whose index equals dstSel. The other three registers keep their values.
- R4: The first operand A is the register indexed by operandField[1:0]. The second operand B is the register indexed by operandField[3:2]. For computing codes, operandField[7:4] has no effect.
- R5: Code 4'hF writes the whole operandField into the destination register and clears the carry flag.
- R6: Code 0 gives A AND B, code 3 gives A OR B, code 4 gives A XOR B, and code 5 gives NOT A. Each of these clears the carry flag.
- R7: Code 1 writes the low 8 bits of A+B. The carry flag takes bit 8 of the 9-bit sum.
- R8: Code 2 writes A-B modulo 256. The carry flag is set exactly when A < B (borrow).
- R9: Code 6 writes A shifted left by one with a zero fill, and the carry flag takes A[7]. Code 7 writes A shifted logically right by one, and the carry flag takes A[0].
- R10: Codes 8 to 14 leave all registers and the carry flag unchanged, even with writeEn high.
- R11: A result written at a rising edge is visible on regBus right after that edge. Register i occupies regBus[8*i+7:8*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| writeEn | input | 1 | Allows register and flag update this cycle |
| opCode | input | 4 | Operation code |
| operandField | input | 8 | Source selects in bits 3:0, or constant for code 4'hF |
| dstSel | input | 2 | Destination register index |
| regBus | output | 32 | All four registers, register i at bits 8*i+7:8*i |
| carryFlag | output | 1 | Captured carry or borrow flag |

## Verification
The embedded assertions check on every cycle that reset clears the state and that a low writeEn or an unused code freezes it. They also check that only the addressed register can change, that a constant load lands in the addressed register, and that logical operations leave the carry clear. The arithmetic values, the shift carries, the borrow rule and the operand routing by select bits are shown only by the bench's directed scenarios. Those scenarios compare every register and the flag against values worked out from the requirements.

// File: rtl/regAluPkg.sv
package regAluPkg;
  localparam logic [3:0] OP_AND  = 4'h0;
  localparam logic [3:0] OP_ADD  = 4'h1;
  localparam logic [3:0] OP_SUB  = 4'h2;
  localparam logic [3:0] OP_OR   = 4'h3;
  localparam logic [3:0] OP_XOR  = 4'h4;
  localparam logic [3:0] OP_NOT  = 4'h5;
  localparam logic [3:0] OP_SHL  = 4'h6;
  localparam logic [3:0] OP_SHR  = 4'h7;
  localparam logic [3:0] OP_LOAD = 4'hF;

  typedef enum logic [2:0] {
    FN_AND, FN_ADD, FN_SUB, FN_OR, FN_XOR, FN_NOT, FN_SHL, FN_SHR
  } aluFn_e;

  typedef struct packed {
    logic   regWr;
    logic   flagWr;
    logic   selImm;
    aluFn_e fn;
  } ctrlStrobe_t;
endpackage

// File: rtl/regAluCtrl.sv
module regAluCtrl
  import regAluPkg::*;
(
  input  logic        writeEn,
  input  logic [3:0]  opCode,
  output ctrlStrobe_t strobe
);
  logic known;

  always_comb begin
    known  = 1'b1;
    strobe = '{regWr: 1'b0, flagWr: 1'b0, selImm: 1'b0, fn: FN_AND};
    case (opCode)
      OP_AND:  strobe.fn = FN_AND;
      OP_ADD:  strobe.fn = FN_ADD;
      OP_SUB:  strobe.fn = FN_SUB;
      OP_OR:   strobe.fn = FN_OR;
      OP_XOR:  strobe.fn = FN_XOR;
      OP_NOT:  strobe.fn = FN_NOT;
      OP_SHL:  strobe.fn = FN_SHL;
      OP_SHR:  strobe.fn = FN_SHR;
      OP_LOAD: strobe.selImm = 1'b1;
      default: known = 1'b0;
    endcase
    strobe.regWr  = writeEn && known;
    strobe.flagWr = writeEn && known;
  end

  always_comb begin
    AST_WE_GATES_WRITE: assert (writeEn || !(strobe.regWr || strobe.flagWr)); // R2
  end
endmodule

// File: rtl/regAluPath.sv
module regAluPath
  import regAluPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobe_t                strobe,
  input  logic [DATA_W-1:0]          operandField,
  input  logic [$clog2(NUM_REGS)-1:0] dstSel,
  output logic [NUM_REGS*DATA_W-1:0] regBus,
  output logic                       carryFlag
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [DATA_W-1:0] opA, opB, aluRes, wrData;
  logic              aluCarry, nextCarry;
  logic [SEL_W-1:0]  selA, selB;

  assign selA = operandField[SEL_W-1:0];
  assign selB = operandField[2*SEL_W-1:SEL_W];
  assign opA  = regFile[selA];
  assign opB  = regFile[selB];

  always_comb begin
    aluCarry = 1'b0;
    aluRes   = '0;
    unique case (strobe.fn)
      FN_AND: aluRes = opA & opB;
      FN_ADD: {aluCarry, aluRes} = {1'b0, opA} + {1'b0, opB};
      FN_SUB: begin
        aluRes   = opA - opB;
        aluCarry = (opA < opB);
      end
      FN_OR:  aluRes = opA | opB;
      FN_XOR: aluRes = opA ^ opB;
      FN_NOT: aluRes = ~opA;
      FN_SHL: {aluCarry, aluRes} = {opA, 1'b0};
      FN_SHR: {aluRes, aluCarry} = {1'b0, opA};
      default: aluRes = '0;
    endcase
  end

  assign wrData    = strobe.selImm ? operandField : aluRes;
  assign nextCarry = strobe.selImm ? 1'b0 : aluCarry;

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    logic hit;
    assign hit = strobe.regWr && (dstSel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (rst)      regFile[i] <= '0;
      else if (hit) regFile[i] <= wrData;
    end
    assign regBus[i*DATA_W +: DATA_W] = regFile[i];

    AST_ONLY_DEST_CHANGES: assert property (@(posedge clk) disable iff (rst)
      (regFile[i] != $past(regFile[i])) |-> ($past(dstSel) == SEL_W'(i))); // R3
  end

  always_ff @(posedge clk) begin
    if (rst)                carryFlag <= 1'b0;
    else if (strobe.flagWr) carryFlag <= nextCarry;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (regBus == '0 && !carryFlag)); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!strobe.regWr && !strobe.flagWr) |=> ($stable(regBus) && $stable(carryFlag))); // R10
endmodule

// File: rtl/regAluCore.sv
module regAluCore
  import regAluPkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        writeEn,
  input  logic [3:0]                  opCode,
  input  logic [DATA_W-1:0]           operandField,
  input  logic [$clog2(NUM_REGS)-1:0] dstSel,
  output logic [NUM_REGS*DATA_W-1:0]  regBus,
  output logic                        carryFlag
);
  ctrlStrobe_t strobe;

  regAluCtrl uCtrl (
    .writeEn (writeEn),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  regAluPath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uPath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .operandField (operandField),
    .dstSel       (dstSel),
    .regBus       (regBus),
    .carryFlag    (carryFlag)
  );

  AST_WE_LOW_FREEZES: assert property (@(posedge clk) disable iff (rst)
    !writeEn |=> ($stable(regBus) && $stable(carryFlag))); // R2
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
    (writeEn && opCode == OP_LOAD) |=>
      (regBus[$past(dstSel)*DATA_W +: DATA_W] == $past(operandField) && !carryFlag)); // R5
  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (writeEn && (opCode == OP_AND || opCode == OP_OR || opCode == OP_XOR || opCode == OP_NOT))
      |=> !carryFlag); // R6
endmodule

// File: tb/regAluCore_test.sv
module regAluCore_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic writeEn = 1'b0;
  logic [3:0] opCode = 4'h0;
  logic [7:0] operandField = 8'h0;
  logic [1:0] dstSel = 2'd0;
  logic [31:0] regBus;
  logic carryFlag;

  int checkCount = 0;
  int failCount = 0;
  logic [7:0] expReg [4];
  logic expCarry;

  regAluCore uut (
    .clk(clk), .rst(rst), .writeEn(writeEn), .opCode(opCode),
    .operandField(operandField), .dstSel(dstSel),
    .regBus(regBus), .carryFlag(carryFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Result per the requirements: {update, carry, value}
  function automatic logic [9:0] specResult(logic [3:0] op, logic [7:0] fld);
    logic [7:0] a, b;
    logic [8:0] s;
    a = expReg[fld[1:0]];
    b = expReg[fld[3:2]];
    case (op)
      4'h0: return {2'b10, a & b};
      4'h1: begin s = {1'b0, a} + {1'b0, b}; return {1'b1, s}; end
      4'h2: return {1'b1, a < b, 8'(a - b)};
      4'h3: return {2'b10, a | b};
      4'h4: return {2'b10, a ^ b};
      4'h5: return {2'b10, ~a};
      4'h6: return {1'b1, a[7], a[6:0], 1'b0};
      4'h7: return {1'b1, a[0], 1'b0, a[7:1]};
      4'hF: return {2'b10, fld};
      default: return 10'h0;
    endcase
  endfunction

  task automatic checkState(string req);
    for (int i = 0; i < 4; i++) begin
      checkCount++;
      if (regBus[i*8 +: 8] !== expReg[i]) begin
        failCount++;
        $display("FAIL %s reg%0d actual %h expected %h", req, i, regBus[i*8 +: 8], expReg[i]);
      end
    end
    checkCount++;
    if (carryFlag !== expCarry) begin
      failCount++;
      $display("FAIL %s carry actual %b expected %b", req, carryFlag, expCarry);
    end
  endtask

  task automatic runOp(logic [3:0] op, logic [7:0] fld, logic [1:0] dst, logic we, string req);
    logic [9:0] r;
    @(negedge clk);
    opCode = op; operandField = fld; dstSel = dst; writeEn = we;
    r = specResult(op, fld);
    @(posedge clk);
    #1;
    writeEn = 1'b0;
    if (we && r[9]) begin
      expReg[dst] = r[7:0];
      expCarry = r[8];
    end
    checkState(req);
  endtask

  task automatic doReset(string req);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) expReg[i] = 8'h00;
    expCarry = 1'b0;
    checkState(req);
  endtask

  task automatic testLoads();
    runOp(4'hF, 8'hA5, 2'd0, 1'b1, "R5");
    runOp(4'hF, 8'h3C, 2'd1, 1'b1, "R5 R11");
    runOp(4'hF, 8'hFF, 2'd2, 1'b1, "R5 R3");
    runOp(4'hF, 8'h81, 2'd3, 1'b1, "R5 R3");
  endtask

  task automatic testLogic();
    runOp(4'h1, 8'b0000_1010, 2'd3, 1'b1, "R7 setup");   // 0xFF+0xFF sets carry
    runOp(4'h0, 8'b0000_0100, 2'd3, 1'b1, "R6 AND");     // A=r0 B=r1
    runOp(4'h1, 8'b0000_1010, 2'd2, 1'b1, "R7 setup");
    runOp(4'h3, 8'b1110_0100, 2'd2, 1'b1, "R6 OR R4");   // upper bits ignored
    runOp(4'h4, 8'b0000_0001, 2'd1, 1'b1, "R6 XOR");     // A=r1 B=r0
    runOp(4'h5, 8'b0000_0000, 2'd0, 1'b1, "R6 NOT");
  endtask

  task automatic testArith();
    runOp(4'hF, 8'hF0, 2'd0, 1'b1, "R5");
    runOp(4'hF, 8'h20, 2'd1, 1'b1, "R5");
    runOp(4'h1, 8'b0000_0100, 2'd2, 1'b1, "R7 carry");     // F0+20 = 110
    runOp(4'h1, 8'b0000_0101, 2'd3, 1'b1, "R7 no carry");  // 20+20
    runOp(4'h2, 8'b0000_0001, 2'd2, 1'b1, "R8 borrow");    // 20-F0
    runOp(4'h2, 8'b0000_0100, 2'd2, 1'b1, "R8 no borrow"); // F0-20
    runOp(4'h2, 8'b0000_0000, 2'd3, 1'b1, "R8 equal");
  endtask

  task automatic testShifts();
    runOp(4'hF, 8'h81, 2'd0, 1'b1, "R5");
    runOp(4'h6, 8'b0000_0000, 2'd1, 1'b1, "R9 SHL");
    runOp(4'h7, 8'b0000_0000, 2'd2, 1'b1, "R9 SHR");
    runOp(4'h7, 8'b0000_0001, 2'd3, 1'b1, "R9 SHR even");
    runOp(4'h6, 8'b0000_0001, 2'd3, 1'b1, "R9 SHL no carry");
  endtask

  task automatic testHolds();
    runOp(4'h1, 8'b0000_0000, 2'd1, 1'b1, "R7 setup"); // 81+81 carry set
    for (int op = 8; op < 15; op++)
      runOp(4'(op), 8'h5A, 2'(op), 1'b1, "R10");
    runOp(4'hF, 8'h77, 2'd0, 1'b0, "R2 load");
    runOp(4'h0, 8'h00, 2'd1, 1'b0, "R2 and");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) expReg[i] = 8'h00;
    expCarry = 1'b0;
    doReset("R1");
    testLoads();
    testLogic();
    testArith();
    testShifts();
    testHolds();
    doReset("R1 midrun");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule